// File: doc/BRIEF.md
# Row/Column Decoded Static RAM

This block is a synchronous model of a 1024-word by 4-bit static RAM. Its 4096 cells sit in a matrix of 64 rows of 64 bit columns. A 10-bit address is split into a row index and a column index, and each index goes to its own one-hot decoder. The row decoder picks one of 64 rows. The column decoder picks one of 16 four-bit groups inside that row.

The bits that form the column index are not contiguous: three low address bits and the top address bit make up the column index. A single 4-bit bidirectional data bus carries data both ways. An active-low chip select enables the part, and an active-low write enable chooses between store and recall. The part drives the bus only while it is selected and reading. At every other time the bus is left to the other devices on it.

The part has no handshake. A write is taken at a rising clock edge. A read follows the address in the same cycle, so it behaves like an asynchronous read with zero access time.

Top module: `rc_sram`

## Requirements
- R1: While rst_n is low, every word is cleared to 4'h0. After reset, every address reads 4'h0 until it is written.
- R2: At a rising edge of clk with cs_n low and we_n low, the 4-bit value on dq is stored at the word selected by addr.
- R3: While cs_n is low and we_n is high, dq carries the stored word at addr in the same cycle that addr is applied. No clock edge is needed.
- R4: dq is high-impedance while cs_n is high, and also while we_n is low. A value that another driver puts on the bus is then seen unchanged.
- R5: While cs_n is high, no word changes, whatever the levels of we_n and dq.
- R6: The row index is addr[8:3]. The column index is {addr[9], addr[2:0]}. Column index k selects bit columns 4k to 4k+3 of the row. Exactly one row line and one column line are active in every cycle.
- R7: Two addresses that differ only in addr[9] select different words. Writing one of them leaves the other unchanged.
- R8: A read is non-destructive. Reading the same address in consecutive cycles returns the same word each time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Writes are taken on the rising edge |
| rst_n | input | 1 | Active-low reset that clears the whole matrix |
| addr | input | 10 | Word address. Row bits are [8:3]; column bits are [9] and [2:0] |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable. High selects a read |
| dq | inout | 4 | Shared data bus. Carries write data in, and read data out during enabled reads |

## Verification
Two outcomes are the hardest to observe from the ports. The first is a write that must not happen while the part is deselected. The second is a pair of addresses that differ only in the top bit and could alias into one column group. Neither shows up at the moment it occurs. The bench therefore fills the whole array with an arithmetic pattern. It then issues deselected write cycles with we_n low, with the bench driving the complement of the stored word on the bus; during those cycles it checks that the bus shows only the bench's own value. Afterwards it reads those locations back. It also writes to pairs of addresses that differ only in addr[9] and reads back both members of each pair.

// File: rtl/rc_sram_pkg.sv
package rc_sram_pkg;
  localparam int unsigned ROW_IDX_W_D = 6;
  localparam int unsigned COL_IDX_W_D = 4;
  localparam int unsigned WORD_W_D    = 4;

  // Split of a flat address into matrix coordinates.
  typedef struct packed {
    logic [ROW_IDX_W_D-1:0] row;
    logic [COL_IDX_W_D-1:0] col;
  } rc_coord_t;
endpackage

// File: rtl/rc_onehot_dec.sv
module rc_onehot_dec #(
  parameter int unsigned IN_W = 4,
  localparam int unsigned OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  idx,
  output logic [OUT_N-1:0] sel
);
  // One output line per code value.
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign sel[i] = (idx == IN_W'(i));
  end
endmodule

// File: rtl/rc_cell_matrix.sv
module rc_cell_matrix #(
  parameter int unsigned ROWS   = 64,
  parameter int unsigned GROUPS = 16,
  parameter int unsigned WORD_W = 4,
  localparam int unsigned ROW_W = GROUPS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROWS-1:0]   row_sel,
  input  logic [GROUPS-1:0] col_sel,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);
  logic [ROWS-1:0][ROW_W-1:0] cells_q;
  logic [ROW_W-1:0]           row_bits;

  // Only the cell group at the crossing of both active lines is written.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells_q <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < GROUPS; c++) begin
          if (row_sel[r] && col_sel[c]) begin
            cells_q[r][c*WORD_W +: WORD_W] <= wr_data;
          end
        end
      end
    end
  end

  // Row lines gate each row onto the shared bit lines.
  always_comb begin
    row_bits = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_sel[r]) row_bits = row_bits | cells_q[r];
    end
  end

  // Column lines steer one 4-bit group to the sense output.
  always_comb begin
    rd_data = '0;
    for (int c = 0; c < GROUPS; c++) begin
      if (col_sel[c]) rd_data = rd_data | row_bits[c*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/rc_sram.sv
module rc_sram
  import rc_sram_pkg::*;
#(
  parameter int unsigned ROW_IDX_W = ROW_IDX_W_D,
  parameter int unsigned COL_IDX_W = COL_IDX_W_D,
  parameter int unsigned WORD_W    = WORD_W_D
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ROW_IDX_W+COL_IDX_W-1:0] addr,
  input  logic                           cs_n,
  input  logic                           we_n,
  inout  wire  [WORD_W-1:0]              dq
);
  localparam int unsigned ADDR_W = ROW_IDX_W + COL_IDX_W;
  localparam int unsigned ROWS   = 1 << ROW_IDX_W;
  localparam int unsigned GROUPS = 1 << COL_IDX_W;
  localparam int unsigned LOW_W  = COL_IDX_W - 1;

  logic [ROW_IDX_W-1:0] row_idx;
  logic [COL_IDX_W-1:0] col_idx;
  logic [ROWS-1:0]      row_sel;
  logic [GROUPS-1:0]    col_sel;
  logic [WORD_W-1:0]    rdata;
  logic                 wr_en;
  logic                 rd_drive;

  // The row field sits between the low column bits and the top column bit.
  assign row_idx = addr[ADDR_W-2:LOW_W];
  assign col_idx = {addr[ADDR_W-1], addr[LOW_W-1:0]};

  assign wr_en    = !cs_n && !we_n;
  assign rd_drive = !cs_n && we_n;

  rc_onehot_dec #(.IN_W(ROW_IDX_W)) u_row_dec (
    .idx(row_idx),
    .sel(row_sel)
  );

  rc_onehot_dec #(.IN_W(COL_IDX_W)) u_col_dec (
    .idx(col_idx),
    .sel(col_sel)
  );

  rc_cell_matrix #(
    .ROWS(ROWS),
    .GROUPS(GROUPS),
    .WORD_W(WORD_W)
  ) u_matrix (
    .clk(clk),
    .rst_n(rst_n),
    .row_sel(row_sel),
    .col_sel(col_sel),
    .wr_en(wr_en),
    .wr_data(dq),
    .rd_data(rdata)
  );

  assign dq = rd_drive ? rdata : {WORD_W{1'bz}};
endmodule

// File: rtl/rc_sram_chk.sv
module rc_sram_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned ROWS   = 64,
  parameter int unsigned GROUPS = 16,
  parameter int unsigned WORD_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              cs_n,
  input logic              we_n,
  input logic [WORD_W-1:0] dq,
  input logic [ROWS-1:0]   row_sel,
  input logic [GROUPS-1:0] col_sel,
  input logic [WORD_W-1:0] rdata
);
  // R2: a word stored in one cycle is read back in the next at the same address.
  a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cs_n && !we_n) && !cs_n && we_n && addr == $past(addr))
      |-> rdata == $past(dq));

  // R3: during an enabled read the bus carries the sensed word.
  a_r3_bus_carries_word: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n) |-> dq == rdata);

  // R5, R8: with no write in the last cycle and a steady address, the word holds.
  a_r5_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(!cs_n && !we_n) && $stable(addr)) |-> $stable(rdata));

  // R6: exactly one row line and one column line are active.
  a_r6_one_row: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_sel) == 1);

  a_r6_one_col: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(col_sel) == 1);
endmodule

bind rc_sram rc_sram_chk #(
  .ADDR_W(ADDR_W),
  .ROWS(ROWS),
  .GROUPS(GROUPS),
  .WORD_W(WORD_W)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .addr(addr),
  .cs_n(cs_n),
  .we_n(we_n),
  .dq(dq),
  .row_sel(row_sel),
  .col_sel(col_sel),
  .rdata(rdata)
);

// File: tb/sim_rc_sram.sv
`timescale 1ns/1ps
module sim_rc_sram;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic       cs_n = 1'b1;
  logic       we_n = 1'b1;
  logic       tb_oe = 1'b0;
  logic [3:0] tb_dq = '0;
  wire  [3:0] dq;
  int checks = 0;
  int failures = 0;
  logic [3:0] model [1024];

  assign dq = tb_oe ? tb_dq : 4'bzzzz;

  always #2 clk = ~clk;

  rc_sram u0 (
    .clk(clk),
    .rst_n(rst_n),
    .addr(addr),
    .cs_n(cs_n),
    .we_n(we_n),
    .dq(dq)
  );

  function automatic logic [3:0] pat(input int a, input int salt);
    pat = 4'((a ^ (a >> 4) ^ (a >> 7) ^ salt) + (a >> 2));
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write cycle: inputs set at the falling edge, stored at the next rising edge.
  task automatic wr(input int a, input logic [3:0] d, input logic sel_n);
    @(negedge clk);
    addr = 10'(a); cs_n = sel_n; we_n = 1'b0; tb_oe = 1'b1; tb_dq = d;
    if (!sel_n) model[a] = d;
  endtask

  // Read cycle: output follows the address within the same cycle.
  task automatic rd(input int a, input string req);
    @(negedge clk);
    addr = 10'(a); cs_n = 1'b0; we_n = 1'b1; tb_oe = 1'b0;
    #1 check(req, dq, model[a]);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) model[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: all words read zero after reset.
    for (int a = 0; a < 1024; a++) rd(a, "R1");

    // R2 R3 R6: full sweep, each location gets its own pattern.
    for (int a = 0; a < 1024; a++) wr(a, pat(a, 0), 1'b0);
    for (int a = 0; a < 1024; a++) rd(a, "R2_R3_R6");

    // R7: pairs that differ only in addr[9].
    for (int a = 0; a < 512; a += 37) begin
      wr(a, 4'h5, 1'b0);
      wr(a | 512, 4'hA, 1'b0);
      rd(a, "R7");
      rd(a | 512, "R7");
    end

    // R5 R4: deselected writes drive the complement; bus must show only the bench value.
    for (int a = 3; a < 1024; a += 61) begin
      wr(a, ~model[a], 1'b1);
      #1 check("R4", dq, ~model[a]);
      rd(a, "R5");
    end

    // R4: deselected read cycle, bench drives the bus; part must stay off it.
    @(negedge clk);
    addr = 10'd100; cs_n = 1'b1; we_n = 1'b1; tb_oe = 1'b1; tb_dq = ~model[100];
    #1 check("R4", dq, ~model[100]);
    @(negedge clk);
    tb_oe = 1'b0;
    // R5: the deselected cycle did not write either.
    rd(100, "R5");

    // R8: back-to-back reads of one address.
    for (int a = 0; a < 1024; a += 97) begin
      rd(a, "R8");
      rd(a, "R8");
    end

    // R2: second full pattern overwrites everything.
    for (int a = 0; a < 1024; a++) wr(a, pat(a, 9), 1'b0);
    for (int a = 0; a < 1024; a++) rd(a, "R2");

    @(negedge clk);
    cs_n = 1'b1; tb_oe = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule